// File: doc/BRIEF.md
# Chainable Four-Channel Interval Timer Bank

Four 16-bit up-counters sit behind a small synchronous register port. Each counter runs on one of two sources. The first is a shared tick strobe, divided by a prescaler that can be set to 1, 64, 256 or 1024. The second is the overflow of the counter one slot below it, which lets two or more counters be joined into one longer counter.

Each slot holds three things: a reload value that can only be written, a live count that can be read, and a control halfword. A counter that wraps past its top value does one of two things. If it runs from ticks, it restarts from its reload value. If it runs from the counter below, it restarts at zero. When its interrupt-enable bit is set, a wrap also sends a one-cycle pulse on that counter's interrupt line.

Software reaches the bank with 16-bit and 32-bit accesses. A read returns data in the same cycle the request is presented. A write takes effect at the next clock edge.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every count, reload and control value is zero, every read returns zero and no interrupt line is high.
- R2: Counter n uses byte offsets 4n to 4n+3. A halfword read at 4n returns the live count. A halfword read at 4n+2 returns all 16 control bits exactly as they were written. A 32-bit read at 4n returns the control value in bits [31:16] and the count in bits [15:0].
- R3: A halfword write at 4n changes only the reload value and leaves the running count unchanged.
- R4: A 32-bit write at 4n takes its low half as the reload value and its high half as the control value. The reload is applied first, so a write that also enables the counter loads the new reload value.
- R5: Byte accesses, halfword accesses at odd addresses, and 32-bit accesses whose address is not a multiple of four are not supported. Such writes change nothing and such reads return zero. In the size field, 0 means byte, 1 means halfword and 2 means 32 bits.
- R6: When control bit 7 (enable) is written from 0 to 1, the count is loaded from the reload value.
- R7: A counter with enable clear, or with control bit 2 (chain) set, does not move on tick strobes.
- R8: An enabled counter that is not chained, and that receives a prescaled step while its count is 0xFFFF, wraps. At that edge it loads its reload value and then keeps counting from there.
- R9: When counter n wraps and counter n+1 is enabled and chained, counter n+1 advances by one at the same edge. If that step takes it past 0xFFFF, counter n+1 wraps at that same edge too, and can step counter n+2 in turn.
- R10: A chained counter that wraps restarts at zero and does not load its reload value.
- R11: The interrupt line of a counter goes high for exactly one cycle, in the cycle after the edge at which the counter wrapped. It does so only if control bit 6 (interrupt enable) was set.
- R12: Control bits [1:0] select a prescale of 1, 64, 256 or 1024 ticks per step for codes 0, 1, 2 and 3. The prescaler restarts from zero whenever the counter is enabled or its prescale code is changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Shared tick strobe that feeds the prescalers |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr_i | input | ADDR_W | Byte offset within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the request |
| irq_o | output | NUM_TMR | One-cycle interrupt pulse for each counter |

## Verification
The bench builds the bank with its default parameters: four counters, each 16 bits wide. At that width, a reload value of 0xFFFE or 0xFFFF brings a wrap within one or two tick strobes, so the bench can test reload on wrap, restart at zero for chained counters, and a wrap passing through three counters at one edge in a few cycles. The 64-step prescale stays within one short run, which lets the bench check the exact step on which the count first moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    localparam int CTL_W    = 16;
    localparam int PRE_W    = 10;
    localparam int BIT_CHN  = 2;
    localparam int BIT_IRQE = 6;
    localparam int BIT_EN   = 7;

    // terminal value of the prescale counter for each division code
    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
        case (code)
            2'd0:    return PRE_W'(0);
            2'd1:    return PRE_W'(63);
            2'd2:    return PRE_W'(255);
            default: return PRE_W'(1023);
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       clr_i,
    input  logic [1:0] code_i,
    output logic       step_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = tick_i && (st_q.cnt == pre_limit(code_i));
        if (clr_i || hit) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o = hit;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             chain_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] rld_val_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             ovf_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [CTL_W-1:0] ctl;
        logic             irq;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        step, pre_clr, en_rise, adv, wrap;

    assign en_rise = ctl_we_i && !st_q.ctl[BIT_EN] && ctl_val_i[BIT_EN];
    assign pre_clr = en_rise || (ctl_we_i && (ctl_val_i[1:0] != st_q.ctl[1:0]));

    tmr_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .clr_i  (pre_clr),
        .code_i (st_q.ctl[1:0]),
        .step_o (step)
    );

    always_comb begin
        st_d = st_q;
        if (rld_we_i) st_d.rld = rld_val_i;
        if (ctl_we_i) st_d.ctl = ctl_val_i;

        adv  = st_q.ctl[BIT_EN] && (st_q.ctl[BIT_CHN] ? chain_i : step);
        wrap = adv && (st_q.cnt == '1);

        if (wrap) begin
            st_d.cnt = st_q.ctl[BIT_CHN] ? '0 : st_d.rld;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // enable edge: reload (already updated by a same-cycle word write) wins
        if (en_rise) st_d.cnt = st_d.rld;

        st_d.irq = wrap && st_q.ctl[BIT_IRQE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ctl_o = st_q.ctl;
    assign ovf_o = wrap;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = $clog2(NUM_TMR * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NUM_TMR-1:0] irq_o
);

    localparam int SLOT_W = ADDR_W - 2;

    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_TMR-1:0][CTL_W-1:0] ctl_w;
    logic [NUM_TMR-1:0]            ovf_w;
    logic [NUM_TMR-1:0]            chain_w;

    logic              wr_act, rd_act, half_ok, word_ok, lo_sel, hi_sel;
    logic [SLOT_W-1:0] slot;
    logic [CTL_W-1:0]  ctl_wval;

    assign wr_act   = req_i && wr_i;
    assign rd_act   = req_i && !wr_i;
    assign slot     = addr_i[ADDR_W-1:2];
    assign half_ok  = (size_i == ACC_HALF) && !addr_i[0];
    assign word_ok  = (size_i == ACC_WORD) && (addr_i[1:0] == 2'b00);
    assign lo_sel   = (half_ok && !addr_i[1]) || word_ok;
    assign hi_sel   = (half_ok && addr_i[1]) || word_ok;
    assign ctl_wval = word_ok ? wdata_i[31:16] : wdata_i[15:0];

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
            logic hit;
            assign hit = wr_act && (slot == SLOT_W'(i));

            if (i == 0) begin : g_head
                assign chain_w[i] = 1'b0;
            end else begin : g_link
                assign chain_w[i] = ovf_w[i-1];
            end

            tmr_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick_i),
                .chain_i   (chain_w[i]),
                .rld_we_i  (hit && lo_sel),
                .rld_val_i (CNT_W'(wdata_i[15:0])),
                .ctl_we_i  (hit && hi_sel),
                .ctl_val_i (ctl_wval),
                .cnt_o     (cnt_w[i]),
                .ctl_o     (ctl_w[i]),
                .ovf_o     (ovf_w[i]),
                .irq_o     (irq_o[i])
            );
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (rd_act) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (slot == SLOT_W'(i)) begin
                    if (word_ok)               rdata_o = {ctl_w[i], CTL_W'(cnt_w[i])};
                    else if (half_ok && addr_i[1]) rdata_o = 32'(ctl_w[i]);
                    else if (half_ok)          rdata_o = 32'(cnt_w[i]);
                end
            end
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_i,
    input logic                          wr_i,
    input logic [1:0]                    size_i,
    input logic [31:0]                   rdata_o,
    input logic [NUM_TMR-1:0]            irq_o,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_i,
    input logic [NUM_TMR-1:0][CTL_W-1:0] ctl_i,
    input logic [NUM_TMR-1:0]            ovf_i,
    input logic [NUM_TMR-1:0]            chain_i
);

    logic wr_act;
    assign wr_act = req_i && wr_i;

    p_byte_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wr_i && size_i == ACC_BYTE) |-> (rdata_o == '0));

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_a
            p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_i[i][BIT_EN] && !wr_act) |=> $stable(cnt_i[i]));

            p_chain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_i[i][BIT_EN] && ctl_i[i][BIT_CHN] && !chain_i[i] && !wr_act)
                |=> $stable(cnt_i[i]));

            p_chain_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_i[i][BIT_EN] && ctl_i[i][BIT_CHN] && chain_i[i] && !wr_act)
                |=> (cnt_i[i] == CNT_W'($past(cnt_i[i]) + 1'b1)));

            p_chain_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf_i[i] && ctl_i[i][BIT_CHN] && !wr_act) |=> (cnt_i[i] == '0));

            p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[i] |-> $past(ovf_i[i] && ctl_i[i][BIT_IRQE]));
        end
    endgenerate

endmodule

bind tmr_bank tmr_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .wr_i    (wr_i),
    .size_i  (size_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .cnt_i   (cnt_w),
    .ctl_i   (ctl_w),
    .ovf_i   (ovf_w),
    .chain_i (chain_w)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
    import tmr_pkg::*;

    localparam int CLK_P   = 10;
    localparam int NUM_TMR = 4;
    localparam int CNT_W   = 16;

    logic               clk, rst_n, tick_i, req_i, wr_i;
    logic [1:0]         size_i;
    logic [3:0]         addr_i;
    logic [31:0]        wdata_i, rdata_o;
    logic [NUM_TMR-1:0] irq_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          ended = 0;

    tmr_bank #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_i(req_i), .wr_i(wr_i),
        .size_i(size_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic cyc(input logic tk, input logic rq, input logic w,
                       input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_i = tk; req_i = rq; wr_i = w; size_i = sz; addr_i = a; wdata_i = d;
    endtask

    task automatic idle(input logic tk);
        cyc(tk, 1'b0, 1'b0, ACC_HALF, 4'd0, 32'd0);
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] d);
        cyc(1'b0, 1'b1, 1'b1, ACC_HALF, a, {16'h0, d});
    endtask

    task automatic wr32(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b0, 1'b1, 1'b1, ACC_WORD, a, d);
    endtask

    // driver: presents a read and queues the value expected from it
    task automatic rd(input logic tk, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        cyc(tk, 1'b1, 1'b0, sz, a, 32'd0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic irq_chk(input logic [NUM_TMR-1:0] exp, input string tag);
        #(CLK_P/4);
        chk(tag, 32'(irq_o), 32'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 0; req_i = 0; wr_i = 0; size_i = 0; addr_i = 0; wdata_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: pops expectations when a read is on the port
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (rst_n && req_i && !wr_i) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL scoreboard actual=%h expected=<none>", rdata_o);
                end else begin
                    chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tick_i = 0; req_i = 0; wr_i = 0; size_i = 0; addr_i = 0; wdata_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 4'd0,  ACC_HALF, 32'h0, "R1 count0");
        rd(0, 4'd6,  ACC_HALF, 32'h0, "R1 ctl1");
        rd(0, 4'd12, ACC_WORD, 32'h0, "R1 word3");
        idle(0);
        irq_chk('0, "R1 irq");

        // R2 / R3 / R6 / R7 on counter 0
        wr16(4'd0, 16'h1234);
        wr16(4'd2, 16'h0080);
        rd(0, 4'd0, ACC_HALF, 32'h0000_1234, "R6 load on enable");
        rd(0, 4'd2, ACC_HALF, 32'h0000_0080, "R2 ctl read");
        rd(0, 4'd0, ACC_WORD, 32'h0080_1234, "R2 word layout");
        wr16(4'd0, 16'h5555);
        rd(0, 4'd0, ACC_HALF, 32'h0000_1234, "R3 reload write keeps count");
        wr16(4'd2, 16'hA93C);
        rd(0, 4'd2, ACC_HALF, 32'h0000_A93C, "R2 ctl readback");
        repeat (3) idle(1);
        rd(0, 4'd0, ACC_HALF, 32'h0000_1234, "R7 disabled ignores ticks");
        wr16(4'd2, 16'h0080);
        rd(0, 4'd0, ACC_HALF, 32'h0000_5555, "R6 latest reload on enable");

        // R4 word write, reload before control
        wr32(4'd4, 32'h00C0_ABCD);
        rd(0, 4'd4, ACC_HALF, 32'h0000_ABCD, "R4 count from new reload");
        rd(0, 4'd6, ACC_HALF, 32'h0000_00C0, "R4 ctl from high half");

        // R5 unsupported accesses
        cyc(0, 1, 1, ACC_BYTE, 4'd10, 32'h0000_0080);
        rd(0, 4'd10, ACC_HALF, 32'h0, "R5 byte write ignored");
        rd(0, 4'd8,  ACC_BYTE, 32'h0, "R5 byte read zero");
        rd(0, 4'd2,  ACC_WORD, 32'h0, "R5 misaligned word read");
        rd(0, 4'd1,  ACC_HALF, 32'h0, "R5 odd halfword read");
        cyc(0, 1, 1, ACC_WORD, 4'd6, 32'hFFFF_FFFF);
        rd(0, 4'd4,  ACC_WORD, 32'h00C0_ABCD, "R5 misaligned write ignored");

        // R8 / R11 wrap with reload
        do_reset();
        wr16(4'd0, 16'hFFFE);
        wr16(4'd2, 16'h00C0);
        rd(0, 4'd0, ACC_HALF, 32'h0000_FFFE, "R6 enable load");
        idle(1);
        rd(1, 4'd0, ACC_HALF, 32'h0000_FFFF, "R8 before wrap");
        irq_chk('0, "R11 no irq before wrap");
        rd(0, 4'd0, ACC_HALF, 32'h0000_FFFE, "R8 reload after wrap");
        irq_chk(4'b0001, "R11 irq after wrap");
        idle(0);
        irq_chk('0, "R11 single-cycle pulse");
        idle(1);
        rd(0, 4'd0, ACC_HALF, 32'h0000_FFFF, "R8 keeps counting");

        // R9 / R10 chain across three counters
        do_reset();
        wr32(4'd4, 32'h00C4_FFFF);
        wr32(4'd8, 32'h0084_0010);
        wr32(4'd0, 32'h0080_FFFF);
        idle(1);
        rd(0, 4'd4, ACC_HALF, 32'h0000_0000, "R10 chained wraps to zero");
        irq_chk(4'b0010, "R11 only enabled irq");
        rd(0, 4'd8, ACC_HALF, 32'h0000_0011, "R9 ripple to third");
        rd(0, 4'd0, ACC_HALF, 32'h0000_FFFF, "R8 head reload");
        wr16(4'd2, 16'h0000);
        repeat (4) idle(1);
        rd(0, 4'd0, ACC_HALF, 32'h0000_FFFF, "R7 disabled head");
        rd(0, 4'd4, ACC_HALF, 32'h0000_0000, "R7 chained ignores ticks");
        irq_chk('0, "R11 quiet");

        // R12 prescale 64
        do_reset();
        wr16(4'd12, 16'h0000);
        wr16(4'd14, 16'h0081);
        repeat (63) idle(1);
        rd(0, 4'd12, ACC_HALF, 32'h0000_0000, "R12 before 64th tick");
        idle(1);
        rd(0, 4'd12, ACC_HALF, 32'h0000_0001, "R12 after 64 ticks");
        // R12 code change restarts prescaler: 40 ticks, switch to 256, 255 ticks
        repeat (40) idle(1);
        wr16(4'd14, 16'h0082);
        repeat (255) idle(1);
        rd(0, 4'd12, ACC_HALF, 32'h0000_0001, "R12 restart on code change");
        idle(1);
        rd(0, 4'd12, ACC_HALF, 32'h0000_0002, "R12 step at 256");

        idle(0);
        idle(0);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        finish_run();
    end

endmodule